// File: doc/BRIEF.md
# Registered Command/Address Buffer with Late Parity Check

This block is the register stage that sits on a memory command and address bus. On each rising clock edge it copies up to 25 data inputs to its outputs, but only when at least one of the two active-low chip-select inputs is low. When both selects are high, the data outputs hold their values. The clock-enable and termination inputs are copied on every edge, whatever the selects are doing. A registered copy of the main chip select is also driven out.

Parity on the bus is even. The parity bit for a word reaches the block one or two clocks after the word itself. A pair of static configuration inputs sets that delay and picks which data bits the parity covers. Inside the block, the covered bits of each captured word are reduced to a single bit. That bit is delayed to line up with the late parity input. When the two meet, the block registers the result as a parity output, high when the total count of ones is odd. The same odd result pulls an active-low error flag low. The flag then stays low for two cycles, and a new error during that time restarts the two cycles. A synchronous active-low reset clears the outputs.

Top module: `cmd_addr_regbuf`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `dout`=0, `par_out`=0, `err_n`=1, `cke_q`=0, `odt_q`=0 and `cs_q_n`=1, and every pending parity check is discarded.
- R2: At a rising edge where `cs_main_n` or `cs_alt_n` (or both) is low, `dout` takes the value of `din`. Bit i of `din` is data line D(i+1).
- R3: At a rising edge where both `cs_main_n` and `cs_alt_n` are high, `dout` keeps its previous value.
- R4: At every rising edge, `cke_q` and `odt_q` take `cke_in` and `odt_in`, and `cs_q_n` takes `cs_main_n`.
- R5: With `cfg_late`=0 and `cfg_narrow`=0, parity covers D2, D3, D5, D6 and D8 through D25.
- R6: With `cfg_late`=0 and `cfg_narrow`=1, parity covers D2, D3, D5, D6 and D8 through D14.
- R7: With `cfg_late`=1, parity covers D1 through D6, D8 through D10, D12 and D13, whatever the value of `cfg_narrow`.
- R8: For a word captured at edge k, `par_in` is sampled at edge k+1 when `cfg_late`=0 and at edge k+2 when `cfg_late`=1. At that edge `par_out` becomes the XOR of the covered bits and `par_in`. At any edge with no captured word due, `par_out` keeps its value.
- R9: At the edge where `par_out` is set to 1, `err_n` goes low. If no further error follows, it stays low for exactly two cycles and then returns high.
- R10: An error found while `err_n` is already low restarts the hold, so `err_n` stays low for two cycles after the latest error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_late | input | 1 | Static: parity delay of two clocks and short-range coverage when 1 |
| cfg_narrow | input | 1 | Static: limits coverage to D2..D14 when `cfg_late`=0 |
| cs_main_n | input | 1 | Main chip select, active low |
| cs_alt_n | input | 1 | Alternate chip select, active low |
| din | input | 25 | Data inputs D1..D25 (bit 0 is D1) |
| cke_in | input | 1 | Clock-enable input |
| odt_in | input | 1 | Termination-control input |
| par_in | input | 1 | Late parity bit for an earlier word |
| dout | output | 25 | Registered data outputs |
| cke_q | output | 1 | Registered clock enable |
| odt_q | output | 1 | Registered termination control |
| cs_q_n | output | 1 | Registered copy of `cs_main_n` |
| par_out | output | 1 | Registered parity result, 1 on odd |
| err_n | output | 1 | Active-low parity error flag, held two cycles |

## Verification
The data, clock-enable, termination and select outputs are due one edge after the inputs are presented. The parity output and the error flag are due at the edge that samples `par_in`, which is one or two edges after the word's capture edge, depending on `cfg_late`. The bench changes inputs on the falling edge and checks outputs at the next falling edge, so each check sees exactly one rising edge's effect. Its reference keeps a two-deep record of captured-word parity, together with an age counter since the last error. With these it predicts the parity and flag values for that edge in each of the four configuration settings.

// File: rtl/regbuf_pkg.sv
// Package: shared types and coverage computation for the registered buffer.
// Assumes data line D(n) sits at bit n-1 of the data vector.
package regbuf_pkg;

    localparam int DATA_W_DEF = 25;
    localparam int MASK_W     = 64;

    typedef enum logic [1:0] {
        COV_WIDE   = 2'd0,
        COV_SHORT  = 2'd1,
        COV_DEEP   = 2'd2
    } cov_mode_e;

    // Decode the two static configuration pins; the reserved late/wide pairing maps to COV_DEEP.
    function automatic cov_mode_e cov_decode(input logic late, input logic narrow);
        if (late)        return COV_DEEP;
        else if (narrow) return COV_SHORT;
        else             return COV_WIDE;
    endfunction

    // Build the coverage mask for a mode; bit n-1 set means line D(n) counts toward parity.
    function automatic logic [MASK_W-1:0] cov_mask(input cov_mode_e mode);
        logic [MASK_W-1:0] m;
        m = '0;
        for (int n = 1; n <= MASK_W; n++) begin
            unique case (mode)
                COV_DEEP:  m[n-1] = (n <= 13) && (n != 7) && (n != 11);
                COV_SHORT: m[n-1] = (n >= 2) && (n <= 14) && (n != 4) && (n != 7);
                default:   m[n-1] = (n >= 2) && (n != 4) && (n != 7);
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/regbuf_capture.sv
// Module: data and control capture registers.
// Data is loaded only when capture is high; the control bits follow their inputs every edge.
// Assumes a synchronous active-low reset.
module regbuf_capture #(
    parameter int DATA_W = regbuf_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    input  logic              cke_in,
    input  logic              odt_in,
    input  logic              cs_main_n,
    output logic [DATA_W-1:0] dout,
    output logic              cke_q,
    output logic              odt_q,
    output logic              cs_q_n
);

    // Data register: loads on a selected edge, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (capture) begin
            dout <= din;
        end
    end

    // Control register: unconditional copy of enable, termination and main select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q  <= 1'b0;
            odt_q  <= 1'b0;
            cs_q_n <= 1'b1;
        end else begin
            cke_q  <= cke_in;
            odt_q  <= odt_in;
            cs_q_n <= cs_main_n;
        end
    end

    AST_DATA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (dout == $past(din)));                          // R2
    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(dout));                                // R3
    AST_CTRL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cke_q == $past(cke_in)) && (odt_q == $past(odt_in))
                 && (cs_q_n == $past(cs_main_n)));                  // R4

endmodule

// File: rtl/regbuf_parity_pipe.sv
// Module: parity reduction, alignment delay and parity result register.
// Each captured word is reduced to one bit over the mode's coverage mask. That bit
// is delayed one or two edges so it meets its late parity bit. Assumes static configuration.
module regbuf_parity_pipe #(
    parameter int DATA_W  = regbuf_pkg::DATA_W_DEF,
    parameter int LAT_MAX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_late,
    input  logic              cfg_narrow,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    input  logic              par_in,
    output logic              par_out,
    output logic              chk_err
);
    import regbuf_pkg::*;

    localparam int IDX_W = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

    cov_mode_e         mode;
    logic [DATA_W-1:0] mask;
    logic              word_par;
    logic [LAT_MAX-1:0] stg_vld;
    logic [LAT_MAX-1:0] stg_par;
    logic [IDX_W-1:0]  tap;
    logic              chk_vld;
    logic              chk_odd;

    // Mode decode and coverage reduction of the incoming word.
    always_comb begin
        mode     = cov_decode(cfg_late, cfg_narrow);
        mask     = cov_mask(mode)[DATA_W-1:0];
        word_par = ^(din & mask);
        tap      = cfg_late ? IDX_W'(LAT_MAX - 1) : '0;
    end

    // First delay stage: record whether a word was captured and its reduced parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld[0] <= 1'b0;
            stg_par[0] <= 1'b0;
        end else begin
            stg_vld[0] <= capture;
            stg_par[0] <= word_par;
        end
    end

    // Further delay stages, one per extra clock of parity latency.
    for (genvar s = 1; s < LAT_MAX; s++) begin : g_stage
        // Shift the captured-word record one stage deeper.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_vld[s] <= 1'b0;
                stg_par[s] <= 1'b0;
            end else begin
                stg_vld[s] <= stg_vld[s-1];
                stg_par[s] <= stg_par[s-1];
            end
        end
    end

    // Combine the aligned word parity with the late parity bit.
    always_comb begin
        chk_vld = stg_vld[tap];
        chk_odd = stg_par[tap] ^ par_in;
        chk_err = chk_vld & chk_odd;
    end

    // Parity result register: updates only when a word is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
        end else if (chk_vld) begin
            par_out <= chk_odd;
        end
    end

    AST_PAR_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_vld |=> $stable(par_out));                             // R8
    AST_PAR_ALIGN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_late && capture) |=> chk_vld);                        // R8
    AST_PAR_ALIGN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_late && capture) |=> ##1 chk_vld);                     // R8

endmodule

// File: rtl/regbuf_err_hold.sv
// Module: active-low error flag with a hold time.
// A pulse on err_evt pulls the flag low for HOLD_CYC cycles, and a new pulse restarts the count.
// Assumes a synchronous active-low reset.
module regbuf_err_hold #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    output logic err_n
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic [CNT_W-1:0] left;

    // Flag and remaining-hold counter: load on an error, count down, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_n <= 1'b1;
            left  <= '0;
        end else if (err_evt) begin
            err_n <= 1'b0;
            left  <= CNT_W'(HOLD_CYC - 1);
        end else if (!err_n) begin
            if (left == '0) begin
                err_n <= 1'b1;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    AST_ERR_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        err_evt |=> !err_n);                                        // R9
    AST_ERR_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);                                   // R9
    AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && left == '0 && !err_evt) |=> err_n);              // R9
    AST_ERR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && err_evt) |=> !err_n ##1 !err_n);                 // R10

endmodule

// File: rtl/cmd_addr_regbuf.sv
// Module: top level of the registered command/address buffer with late parity check.
// Capture is enabled when either chip select is low. The configuration pins are
// assumed static while out of reset, so a change must be followed by a reset.
module cmd_addr_regbuf #(
    parameter int DATA_W   = regbuf_pkg::DATA_W_DEF,
    parameter int LAT_MAX  = 2,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_late,
    input  logic              cfg_narrow,
    input  logic              cs_main_n,
    input  logic              cs_alt_n,
    input  logic [DATA_W-1:0] din,
    input  logic              cke_in,
    input  logic              odt_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] dout,
    output logic              cke_q,
    output logic              odt_q,
    output logic              cs_q_n,
    output logic              par_out,
    output logic              err_n
);

    logic capture;
    logic chk_err;

    // Capture enable: either active-low select asserted.
    always_comb begin
        capture = !(cs_main_n && cs_alt_n);
    end

    regbuf_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .din       (din),
        .cke_in    (cke_in),
        .odt_in    (odt_in),
        .cs_main_n (cs_main_n),
        .dout      (dout),
        .cke_q     (cke_q),
        .odt_q     (odt_q),
        .cs_q_n    (cs_q_n)
    );

    regbuf_parity_pipe #(.DATA_W(DATA_W), .LAT_MAX(LAT_MAX)) u_parity (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_late   (cfg_late),
        .cfg_narrow (cfg_narrow),
        .capture    (capture),
        .din        (din),
        .par_in     (par_in),
        .par_out    (par_out),
        .chk_err    (chk_err)
    );

    regbuf_err_hold #(.HOLD_CYC(HOLD_CYC)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .err_evt (chk_err),
        .err_n   (err_n)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (dout == '0) && !par_out && err_n && !cke_q && !odt_q && cs_q_n); // R1
    AST_ERR_WITH_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> par_out);                                  // R9

endmodule

// File: tb/tb_cmd_addr_regbuf.sv
module tb_cmd_addr_regbuf;
    localparam int W = 25;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, cfg_late = 1'b0, cfg_narrow = 1'b0;
    logic cs_main_n = 1'b1, cs_alt_n = 1'b1, cke_in = 1'b0, odt_in = 1'b0, par_in = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic cke_q, odt_q, cs_q_n, par_out, err_n;

    cmd_addr_regbuf dut (
        .clk(clk), .rst_n(rst_n), .cfg_late(cfg_late), .cfg_narrow(cfg_narrow),
        .cs_main_n(cs_main_n), .cs_alt_n(cs_alt_n), .din(din), .cke_in(cke_in),
        .odt_in(odt_in), .par_in(par_in), .dout(dout), .cke_q(cke_q), .odt_q(odt_q),
        .cs_q_n(cs_q_n), .par_out(par_out), .err_n(err_n)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state
    logic [W-1:0] m_dout;
    logic m_cke, m_odt, m_csq, m_par;
    int   m_age;
    bit   m_restart;
    bit   h_v1, h_p1, h_v2, h_p2;
    logic [31:0] lfsr = 32'h1D5C_93A7;

    function automatic bit covered(int n, bit late, bit narrow);
        if (late) return (n <= 6 && n != 7) || (n >= 8 && n <= 10) || n == 12 || n == 13;
        if (n == 1 || n == 4 || n == 7) return 0;
        return narrow ? (n <= 14) : 1'b1;
    endfunction

    function automatic bit ref_parity(logic [W-1:0] d, bit late, bit narrow);
        int ones = 0;
        for (int n = 1; n <= W; n++) if (covered(n, late, narrow) && d[n-1]) ones++;
        return ones % 2;
    endfunction

    function automatic string mode_req();
        if (cfg_late) return "R7";
        return cfg_narrow ? "R6" : "R5";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic cyc(logic r, logic [W-1:0] d, logic c0n, logic c1n, logic ke, logic ot, logic p);
        bit sel, hv, hp, cur;
        string preq;
        rst_n = r; din = d; cs_main_n = c0n; cs_alt_n = c1n;
        cke_in = ke; odt_in = ot; par_in = p;
        sel = !(c0n && c1n);
        @(posedge clk);
        if (!r) begin
            m_dout = '0; m_cke = 0; m_odt = 0; m_csq = 1; m_par = 0;
            m_age = 99; m_restart = 0;
            h_v1 = 0; h_p1 = 0; h_v2 = 0; h_p2 = 0;
            preq = "R1";
        end else begin
            cur = ref_parity(d, cfg_late, cfg_narrow);
            hv = cfg_late ? h_v2 : h_v1;
            hp = cfg_late ? h_p2 : h_p1;
            preq = hv ? {mode_req(), " R8"} : "R8";
            if (hv) m_par = hp ^ p;
            if (hv && m_par) begin
                m_restart = (m_age < 2);
                m_age = 0;
            end else if (m_age < 99) begin
                m_age++;
            end
            if (m_age >= 2) m_restart = 0;
            h_v2 = h_v1; h_p2 = h_p1; h_v1 = sel; h_p1 = cur;
            if (sel) m_dout = d;
            m_cke = ke; m_odt = ot; m_csq = c0n;
        end
        @(negedge clk);
        chk(!r ? "R1" : (sel ? "R2" : "R3"), dout, m_dout);
        chk(!r ? "R1" : "R4", {cke_q, odt_q, cs_q_n}, {m_cke, m_odt, m_csq});
        chk(preq, par_out, m_par);
        chk(!r ? "R1" : (m_restart ? "R10" : "R9"), err_n, (m_age < 2) ? 1'b0 : 1'b1);
    endtask

    initial begin : main
        for (int md = 0; md < 4; md++) begin
            cfg_late = md[1]; cfg_narrow = md[0];
            cyc(0, '1, 0, 0, 1, 1, 1);
            cyc(0, '0, 1, 1, 0, 0, 0);
            // Walking one across every line, selected on alternating selects (R5 R6 R7)
            for (int n = 0; n < W; n++) begin
                cyc(1, W'(1) << n, n[0], !n[0], n[1], n[2], 1'b0);
                cyc(1, '0, 1, 1, 0, 0, 1'b0);
                cyc(1, '0, 1, 1, 0, 0, 1'b0);
            end
            // Back-to-back errors restart the hold (R10): D2 is covered in every mode
            cyc(1, W'(2), 0, 1, 0, 0, 0);
            cyc(1, W'(2), 0, 1, 0, 0, 0);
            cyc(1, W'(2), 0, 1, 0, 0, 0);
            for (int k = 0; k < 5; k++) cyc(1, '0, 1, 1, 0, 0, 0);
            // Pseudo-random traffic over selects, data and late parity
            for (int k = 0; k < 300; k++) begin
                step();
                cyc(1, lfsr[W-1:0] ^ {lfsr[6:0], lfsr[31:14]}, lfsr[25] & lfsr[26],
                    lfsr[27] | lfsr[3], lfsr[28], lfsr[29], lfsr[30]);
            end
            cyc(0, '1, 0, 0, 1, 1, 1);
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule